// File: doc/BRIEF.md
# Translation Storage Buffer Pointer Generator

This block serves one memory-management unit, either the instruction side or the data side, chosen by a parameter. It holds four translation-storage-buffer (TSB) base registers and the page-size fields of two context configuration registers. All of them are loaded through an address-space-identifier (ASI) store port. From the tag access value it forms, with no clock delay, the address of the 16-byte TSB entry for one of two page-size slots. A trap handler reads this address after a TLB miss.

When the hypervisor-present input is low, the block behaves as an older design. A single externally held TSB register serves both slots. The page size is fixed at 8K for slot 0 and 64K for slot 1. In this mode the extended register stores are refused and raise an illegal-instruction flag.

Top module: `mmu_tsb_ptr_gen`

## Requirements
- R1: Reset (rst_n low) clears all four base registers and both page-size configurations to zero.
- R2: With hv_mode high, a store to one of the side's base ASIs loads st_data into the base register whose index is {asi[3], asi[1]}. The data-side ASIs are 0x31→0, 0x32→1, 0x39→2 and 0x3A→3. The new value is visible after the next rising clock edge.
- R3: With hv_mode high, a store to a config ASI (data side 0x33 and 0x3B, with asi[3] selecting config 0 or 1) loads two page-size codes: st_data[2:0] for slot 0 and st_data[10:8] for slot 1. All other data bits are ignored.
- R4: When tag_access[12:0] is zero, config 0 and base registers 0 and 1 are used. Any nonzero value selects config 1 and base registers 2 and 3. The base index is {context nonzero, rd_slot}.
- R5: Let the VA be tag_access with bits [12:0] cleared, shifted right by 3·ps+9, where ps is the page-size code. Let size be tsb[3:0]. The pointer takes tsb bits at and above 13+size (+1 when split) and takes VA bits below that.
- R6: When the split flag tsb[12] is set, pointer bit 13+size equals rd_slot.
- R7: tsb_ptr[3:0] is always zero, giving 16-byte entry alignment.
- R8: With hv_mode low, legacy_tsb is used for both slots, and the page-size code equals rd_slot.
- R9: With hv_mode low, a store to any of the side's six extended ASIs raises illegal_insn in the same cycle and changes no register.
- R10: Stores to other ASIs, including the other side's (instruction side: 0x35, 0x36, 0x3D, 0x3E, 0x37, 0x3F), neither write nor raise illegal_insn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hv_mode | input | 1 | Hypervisor present: extended registers in use |
| st_valid | input | 1 | ASI store strobe |
| st_asi | input | 8 | ASI of the store |
| st_data | input | 64 | Store data |
| legacy_tsb | input | 64 | Single TSB register value for legacy mode |
| tag_access | input | 64 | Tag access value: VA in [63:13], context in [12:0] |
| rd_slot | input | 1 | Page-size slot of the pointer read (0 or 1) |
| tsb_ptr | output | 64 | Computed TSB entry address |
| illegal_insn | output | 1 | Extended ASI store attempted without hypervisor |

## Verification
The bench sweeps every size field, both split settings and every page-size code. Each combination is tried against zero and nonzero contexts and both slots. Each config register carries a different size code per slot, and each base register has a distinct base value, so a wrong register or field choice shows in the pointer. A legacy sweep covers both slots across all sizes and split settings, which tells the fixed-size path apart from the configured one. Refused stores and stores to foreign ASIs are followed by pointer reads that would expose any stray write.

// File: rtl/mmu_tsb_pkg.sv
// Package: shared widths and field positions for the TSB pointer generator.
// Assumes 64-bit registers and a 13-bit context in the tag access value.
package mmu_tsb_pkg;
    localparam int DW        = 64;
    localparam int CTX_W     = 13;
    localparam int PS_W      = 3;
    localparam int SZ_W      = 4;
    localparam int SPLIT_BIT = 12;
    localparam int BASE_LSB  = 13;
    localparam int ENTRY_LSB = 4;
    localparam int NBASE     = 4;
    localparam int NCFG      = 2;
    localparam int PS0_LSB   = 0;
    localparam int PS1_LSB   = 8;

    typedef logic [DW-1:0] word_t;
    typedef logic [PS_W-1:0] ps_t;
endpackage

// File: rtl/tsb_cfg_regs.sv
// Register file: decodes ASI stores for one MMU side, holds four base registers
// and two pairs of page-size codes. Raises the illegal flag when hypervisor is absent.
// Assumes the side is identified by ASI bit 2 (0 = data, 1 = instruction).
module tsb_cfg_regs
    import mmu_tsb_pkg::*;
#(
    parameter bit IS_DATA = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hv_mode,
    input  logic                          st_valid,
    input  logic [7:0]                    st_asi,
    input  word_t                         st_data,
    output logic [NBASE-1:0][DW-1:0]      base_q,
    output logic [NCFG-1:0][1:0][PS_W-1:0] ps_q,
    output logic                          illegal
);
    localparam logic SIDE_BIT = ~IS_DATA;

    logic       side_hit;
    logic       is_cfg;
    logic       wr_base;
    logic       wr_cfg;
    logic [1:0] widx;

    // Decode: the six extended ASIs of this side share [7:4]=3 and bit 2 = side.
    always_comb begin
        side_hit = st_valid && (st_asi[7:4] == 4'h3) && (st_asi[2] == SIDE_BIT)
                   && (st_asi[1:0] != 2'b00);
        is_cfg   = (st_asi[1:0] == 2'b11);
        wr_base  = side_hit && hv_mode && !is_cfg;
        wr_cfg   = side_hit && hv_mode && is_cfg;
        illegal  = side_hit && !hv_mode;
        widx     = {st_asi[3], st_asi[1]};
    end

    for (genvar k = 0; k < NBASE; k++) begin : g_base
        // Base register k: loads store data when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[k] <= '0;
            else if (wr_base && (widx == 2'(k)))
                base_q[k] <= st_data;
        end
    end

    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
        // Config c: keeps only the two page-size fields.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ps_q[c] <= '0;
            end else if (wr_cfg && (st_asi[3] == 1'(c))) begin
                ps_q[c][0] <= st_data[PS0_LSB +: PS_W];
                ps_q[c][1] <= st_data[PS1_LSB +: PS_W];
            end
        end
    end
endmodule

// File: rtl/tsb_ptr_calc.sv
// Pointer arithmetic: shifts the VA by the page-size code, builds the base mask
// from the size and split fields, forces the split bit, and merges. Purely combinational.
module tsb_ptr_calc
    import mmu_tsb_pkg::*;
(
    input  word_t                   tsb,
    input  logic [DW-1:BASE_LSB]    va_hi,
    input  ps_t                     ps,
    input  logic                    slot,
    output word_t                   ptr
);
    logic [4:0]      shamt;
    logic [SZ_W-1:0] size;
    logic            split;
    logic [5:0]      fbit;
    word_t           va;
    word_t           mask;
    word_t           merged;

    // Merge: base bits above the mask edge, shifted VA bits below it.
    always_comb begin
        shamt = {2'b00, ps} + {1'b0, ps, 1'b0} + 5'd9;
        size  = tsb[SZ_W-1:0];
        split = tsb[SPLIT_BIT];
        fbit  = 6'(BASE_LSB) + {2'b00, size};
        va    = {va_hi, {BASE_LSB{1'b0}}} >> shamt;
        mask  = (~word_t'({BASE_LSB{1'b1}})) << size;
        if (split) begin
            mask     = mask << 1;
            va[fbit] = slot;
        end
        merged = (tsb & mask) | (va & ~mask);
        ptr    = {merged[DW-1:ENTRY_LSB], {ENTRY_LSB{1'b0}}};
    end
endmodule

// File: rtl/mmu_tsb_ptr_gen.sv
// Top: TSB pointer generator for one MMU side. Selects register and page size from
// the context and slot (or the legacy register and fixed sizes) and forms the pointer.
// Assumes at most one ASI store per cycle; reads are combinational.
module mmu_tsb_ptr_gen
    import mmu_tsb_pkg::*;
#(
    parameter bit IS_DATA = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hv_mode,
    input  logic        st_valid,
    input  logic [7:0]  st_asi,
    input  logic [63:0] st_data,
    input  logic [63:0] legacy_tsb,
    input  logic [63:0] tag_access,
    input  logic        rd_slot,
    output logic [63:0] tsb_ptr,
    output logic        illegal_insn
);
    logic [NBASE-1:0][DW-1:0]       base_q;
    logic [NCFG-1:0][1:0][PS_W-1:0] ps_q;
    logic                           ctx_nz;
    word_t                          tsb_sel;
    ps_t                            ps_sel;

    tsb_cfg_regs #(.IS_DATA(IS_DATA)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hv_mode  (hv_mode),
        .st_valid (st_valid),
        .st_asi   (st_asi),
        .st_data  (st_data),
        .base_q   (base_q),
        .ps_q     (ps_q),
        .illegal  (illegal_insn)
    );

    // Selection: context and slot pick register and size, or legacy fixed mapping.
    always_comb begin
        ctx_nz = |tag_access[CTX_W-1:0];
        if (hv_mode) begin
            tsb_sel = base_q[{ctx_nz, rd_slot}];
            ps_sel  = ps_q[ctx_nz][rd_slot];
        end else begin
            tsb_sel = legacy_tsb;
            ps_sel  = {{(PS_W-1){1'b0}}, rd_slot};
        end
    end

    tsb_ptr_calc u_calc (
        .tsb   (tsb_sel),
        .va_hi (tag_access[DW-1:BASE_LSB]),
        .ps    (ps_sel),
        .slot  (rd_slot),
        .ptr   (tsb_ptr)
    );
endmodule

// File: rtl/mmu_tsb_ptr_gen_chk.sv
// Checker: temporal properties on the register file and illegal flag of the
// TSB pointer generator. Attached by bind below.
module mmu_tsb_ptr_gen_chk
    import mmu_tsb_pkg::*;
#(
    parameter bit IS_DATA = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hv_mode,
    input  logic                           st_valid,
    input  logic [7:0]                     st_asi,
    input  logic [63:0]                    st_data,
    input  logic                           illegal_insn,
    input  logic [NBASE-1:0][DW-1:0]       base_q,
    input  logic [NCFG-1:0][1:0][PS_W-1:0] ps_q
);
    localparam logic SIDE_BIT = ~IS_DATA;

    logic ext_hit;
    logic base_hit;
    // Independent decode of the side's extended ASIs.
    assign ext_hit  = st_valid && (st_asi[7:4] == 4'h3) && (st_asi[2] == SIDE_BIT)
                      && (st_asi[1:0] != 2'b00);
    assign base_hit = ext_hit && (st_asi[1:0] != 2'b11);

    for (genvar k = 0; k < NBASE; k++) begin : g_wr
        assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (hv_mode && base_hit && ({st_asi[3], st_asi[1]} == 2'(k)))
            |=> (base_q[k] == $past(st_data)));
    end

    assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_mode && ext_hit && st_asi[1:0] == 2'b11)
        |=> (ps_q[$past(st_asi[3])][1] == $past(st_data[10:8])));

    assert_refused_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_insn |=> ($stable(base_q) && $stable(ps_q)));

    assert_illegal_only_legacy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_insn |-> (!hv_mode && st_valid));

    assert_foreign_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_hit |=> ($stable(base_q) && $stable(ps_q)));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (base_q == '0 && ps_q == '0));
endmodule

bind mmu_tsb_ptr_gen mmu_tsb_ptr_gen_chk #(.IS_DATA(IS_DATA)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hv_mode      (hv_mode),
    .st_valid     (st_valid),
    .st_asi       (st_asi),
    .st_data      (st_data),
    .illegal_insn (illegal_insn),
    .base_q       (base_q),
    .ps_q         (ps_q)
);

// File: tb/mmu_tsb_ptr_gen_bench.sv
// Bench: sweeps size, split, page-size codes, contexts and slots on the data side;
// expected pointers are built bit by bit from the requirements.
module mmu_tsb_ptr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_mode = 1'b1;
    logic        st_valid = 1'b0;
    logic [7:0]  st_asi = 8'h00;
    logic [63:0] st_data = '0;
    logic [63:0] legacy_tsb = '0;
    logic [63:0] tag_access = '0;
    logic        rd_slot = 1'b0;
    logic [63:0] tsb_ptr;
    logic        illegal_insn;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    mmu_tsb_ptr_gen u_mmu_tsb_ptr_gen (
        .clk(clk), .rst_n(rst_n), .hv_mode(hv_mode), .st_valid(st_valid),
        .st_asi(st_asi), .st_data(st_data), .legacy_tsb(legacy_tsb),
        .tag_access(tag_access), .rd_slot(rd_slot), .tsb_ptr(tsb_ptr),
        .illegal_insn(illegal_insn)
    );

    // Expected pointer, one bit at a time from the requirement text.
    function automatic logic [63:0] model(input logic [63:0] tsb, input logic [63:0] tag,
                                          input int ps, input int slot);
        logic [63:0] r;
        logic [63:0] va;
        int sz  = int'(tsb[3:0]);
        int sp  = int'(tsb[12]);
        int lim = 13 + sz + sp;
        va = {tag[63:13], 13'b0} >> (3 * ps + 9);
        for (int b = 0; b < 64; b++) begin
            if (b < 4)             r[b] = 1'b0;
            else if (b < lim)      r[b] = va[b];
            else                   r[b] = tsb[b];
            if (sp == 1 && b == 13 + sz) r[b] = slot[0];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [7:0] asi, input logic [63:0] d);
        @(posedge clk); #1;
        st_valid = 1'b1; st_asi = asi; st_data = d;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic read(input string req, input logic [63:0] tag, input logic s,
                        input logic [63:0] exp);
        tag_access = tag; rd_slot = s;
        @(negedge clk);
        check(req, tsb_ptr, exp);
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] bv [4];
        logic [63:0] t0, t1, va;
        int it, p00, p01, p10, p11;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: zero registers, size 0, page code 0.
        t0 = 64'h1234_5678_9ABC_E000;
        read("R1", t0, 1'b0, model(64'h0, t0, 0, 0));
        read("R1", t0 | 64'h5, 1'b1, model(64'h0, t0, 0, 1));

        // R2 R3 R4 R5 R6: full sweep in hypervisor mode.
        it = 0;
        for (int sz = 0; sz < 16; sz++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int ps = 0; ps < 8; ps++) begin
                    for (int k = 0; k < 4; k++)
                        bv[k] = ((64'h9E37_79B9_7F4A_7C15 * 64'(it * 4 + k + 1)) & ~64'h1FFF)
                                | 64'h0AB0 | (64'(sp) << 12) | 64'(sz);
                    p00 = ps; p01 = (ps + 3) % 8; p10 = (ps + 5) % 8; p11 = (ps + 1) % 8;
                    store(8'h31, bv[0]);
                    store(8'h32, bv[1]);
                    store(8'h39, bv[2]);
                    store(8'h3A, bv[3]);
                    store(8'h33, 64'hFFFF_0000_0000_F8F8 | 64'(p00) | (64'(p01) << 8));
                    store(8'h3B, 64'hFFFF_0000_0000_F8F8 | 64'(p10) | (64'(p11) << 8));
                    va = (64'hC2B2_AE3D_27D4_EB4F * 64'(it + 3)) & ~64'h1FFF;
                    t0 = va;
                    t1 = va | 64'(13'h1 << (it % 13));
                    read(sp ? "R6" : "R5", t0, 1'b0, model(bv[0], t0, p00, 0));
                    read("R3", t0, 1'b1, model(bv[1], t0, p01, 1));
                    read("R4", t1, 1'b0, model(bv[2], t1, p10, 0));
                    read("R2", t1, 1'b1, model(bv[3], t1, p11, 1));
                    it++;
                end
            end
        end

        // R7: entry alignment.
        n_chk++;
        if (tsb_ptr[3:0] !== 4'h0) begin
            n_err++;
            $display("FAIL R7: actual=%h expected=0", tsb_ptr[3:0]);
        end

        // R9: refused stores flag illegal and leave registers alone.
        hv_mode = 1'b0;
        @(posedge clk); #1;
        st_valid = 1'b1; st_asi = 8'h31; st_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R9", {63'b0, illegal_insn}, 64'h1);
        @(posedge clk); #1;
        st_asi = 8'h3B; st_data = 64'h0707;
        @(negedge clk);
        check("R9", {63'b0, illegal_insn}, 64'h1);
        @(posedge clk); #1;
        st_valid = 1'b0;
        hv_mode = 1'b1;
        read("R9", t0, 1'b0, model(bv[0], t0, p00, 0));
        read("R9", t1, 1'b1, model(bv[3], t1, p11, 1));

        // R10: instruction-side and unrelated ASIs are ignored on the data side.
        foreach (bv[k]) begin end
        begin
            logic [7:0] foreign [6] = '{8'h35, 8'h3E, 8'h37, 8'h3F, 8'h30, 8'h3C};
            for (int f = 0; f < 6; f++) begin
                @(posedge clk); #1;
                st_valid = 1'b1; st_asi = foreign[f]; st_data = 64'hDEAD_BEEF_0000_0505;
                @(negedge clk);
                check("R10", {63'b0, illegal_insn}, 64'h0);
                @(posedge clk); #1;
                st_valid = 1'b0;
            end
        end
        read("R10", t0, 1'b1, model(bv[1], t0, p01, 1));
        read("R10", t1, 1'b0, model(bv[2], t1, p10, 0));

        // R8: legacy mode, single register, fixed sizes.
        hv_mode = 1'b0;
        for (int sz = 0; sz < 16; sz++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int s = 0; s < 2; s++) begin
                    legacy_tsb = ((64'hA5A5_3C3C_0F0F_9696 ^ (64'(sz) << 40)) & ~64'h1FFF)
                                 | (64'(sp) << 12) | 64'(sz);
                    t0 = (64'hF00D_CAFE_1357_9BDF + 64'(sz * 64'h1_0000_2000)) | 64'h3;
                    read("R8", t0, s[0], model(legacy_tsb, t0, s, s));
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule